// File: doc/BRIEF.md
# Burst Memory Address Sequencer

This block produces the word address that a synchronous burst memory array sees during a four-beat burst. At a rising clock edge where either of two active-low address strobes is asserted, it captures a starting word address. After that, each edge on which the active-low advance input is asserted moves the burst one beat forward. Only the two least-significant address bits change during the burst. The upper bits keep the value captured at load time.

A static order input picks how the two low bits step. In linear order, the beat count is added to the starting low bits modulo four. In interleaved order, the beat count is XORed with the starting low bits. Chip-select qualification happens upstream, so any strobe that reaches this block is treated as a valid load. The address output is combinational from the block's registers, so a load or advance sampled at an edge shows up on the output right after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the captured address and the beat count clear. `word_addr` reads zero after reset.
- R2: If `proc_strobe_n` or `ctrl_strobe_n` is low at a rising edge, `word_addr` equals the `start_addr` sampled at that edge, and the beat count restarts at zero.
- R3: If neither strobe is low and `adv_n` is high at a rising edge, `word_addr` keeps its value.
- R4: When `order_sel` is 0 (linear), the low two bits of `word_addr` are (start low bits + beat) mod 4. For example, a start of 1 gives 1,2,3,0.
- R5: When `order_sel` is 1 (interleaved), the low two bits are (start low bits XOR beat). For example, a start of 1 gives 1,0,3,2.
- R6: The beat count is two bits wide. After four advances, the burst wraps back to the starting low bits.
- R7: Bits above bit 1 of `word_addr` stay at the captured value for the whole burst. Advances never change them.
- R8: A load has priority over an advance at the same edge. The advance input has no effect in a cycle where either strobe loads.
- R9: Both strobes low at the same edge perform one load, the same as a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| order_sel | input | 1 | Static burst order: 0 linear, 1 interleaved |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| start_addr | input | ADDR_W | Starting word address captured on a load |
| word_addr | output | ADDR_W | Current word address for the memory array |

## Verification
Each load or advance is sampled at a rising edge, and its result appears on `word_addr` before the next falling edge. No additional pipeline delay applies. The bench drives all inputs at falling edges and updates a behavioural model at the following rising edge. It then compares `word_addr` with the model at the next falling edge, so every cycle yields one comparison with the result due from the edge just passed. Changes to the order input are applied at a falling edge while the burst is idle. The model recomputes the output from the new order at the next comparison.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_BITS = 2;

    typedef logic [BEAT_BITS-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } order_e;

    typedef struct packed {
        logic  load;
        logic  step;
    } seq_ctrl_t;

    function automatic beat_t map_low(input beat_t start_lo, input beat_t beat, input order_e ord);
        beat_t res;
        if (ord == ORD_INTERLEAVED)
            res = start_lo ^ beat;
        else
            res = start_lo + beat;
        return res;
    endfunction

endpackage

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R7
endmodule

// File: rtl/bsq_beat_counter.sv
module bsq_beat_counter
    import burst_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  seq_ctrl_t ctrl,
    output beat_t     beat
);
    always_ff @(posedge clk) begin
        if (rst)
            beat <= '0;
        else if (ctrl.load)
            beat <= '0;
        else if (ctrl.step)
            beat <= beat + beat_t'(1);
    end

    AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.load && ctrl.step && beat == '1) |=> beat == '0); // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (ctrl.load && ctrl.step) |=> beat == '0); // R8
endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base,
    input  beat_t             beat,
    input  order_e            ord,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - BEAT_BITS;

    generate
        if (HI_W > 0) begin : g_hi
            assign addr[ADDR_W-1:BEAT_BITS] = base[ADDR_W-1:BEAT_BITS];
        end
    endgenerate

    assign addr[BEAT_BITS-1:0] = map_low(base[BEAT_BITS-1:0], beat, ord);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              order_sel,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] word_addr
);
    seq_ctrl_t              ctrl;
    logic [ADDR_W-1:0]      base_q;
    beat_t                  beat_q;
    order_e                 ord;

    always_comb begin
        ctrl.load = !proc_strobe_n || !ctrl_strobe_n;
        ctrl.step = !adv_n;
    end

    assign ord = order_e'(order_sel);

    bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk  (clk),
        .rst  (rst),
        .load (ctrl.load),
        .d    (start_addr),
        .q    (base_q)
    );

    bsq_beat_counter u_beat (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .beat (beat_q)
    );

    bsq_order_map #(.ADDR_W(ADDR_W)) u_map (
        .base (base_q),
        .beat (beat_q),
        .ord  (ord),
        .addr (word_addr)
    );

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n || !ctrl_strobe_n) |=> word_addr == $past(start_addr)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (proc_strobe_n && ctrl_strobe_n && adv_n) ##1 $stable(order_sel) |-> $stable(word_addr)); // R3
    AST_ADV_MOVES: assert property (@(posedge clk) disable iff (rst)
        (proc_strobe_n && ctrl_strobe_n && !adv_n) ##1 $stable(order_sel) |->
            word_addr[BEAT_BITS-1:0] != $past(word_addr[BEAT_BITS-1:0])); // R4
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (proc_strobe_n && ctrl_strobe_n) |=>
            word_addr[ADDR_W-1:BEAT_BITS] == $past(word_addr[ADDR_W-1:BEAT_BITS])); // R7
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          order_sel;
    logic          proc_strobe_n;
    logic          ctrl_strobe_n;
    logic          adv_n;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] word_addr;

    int n_checks = 0;
    int n_fail   = 0;

    int m_base = 0;
    int m_beat = 0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .order_sel     (order_sel),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .start_addr    (start_addr),
        .word_addr     (word_addr)
    );

    function automatic logic [AW-1:0] model_addr();
        int lo;
        int low2;
        lo = m_base % 4;
        if (order_sel)
            low2 = lo ^ m_beat;
        else
            low2 = (lo + m_beat) % 4;
        return AW'((m_base / 4) * 4 + low2);
    endfunction

    task automatic compare(input string tag);
        logic [AW-1:0] exp;
        exp = model_addr();
        n_checks++;
        if (word_addr !== exp) begin
            n_fail++;
            $display("FAIL %s: word_addr=%h expected=%h", tag, word_addr, exp);
        end
    endtask

    // drive at falling edge, model at rising edge, compare at next falling edge
    task automatic cyc(input logic ps_n, input logic cs_n, input logic av_n,
                       input logic [AW-1:0] a, input string tag);
        proc_strobe_n = ps_n;
        ctrl_strobe_n = cs_n;
        adv_n         = av_n;
        start_addr    = a;
        @(posedge clk);
        if (rst) begin
            m_base = 0;
            m_beat = 0;
        end else if (!ps_n || !cs_n) begin
            m_base = int'(a);
            m_beat = 0;
        end else if (!av_n) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        order_sel = 1'b0;
        @(negedge clk);
        cyc(1'b0, 1'b1, 1'b0, 20'hABCDE, "R1 reset ignores strobe");
        cyc(1'b1, 1'b1, 1'b0, 20'h00000, "R1 reset");
        rst = 1'b0;
        cyc(1'b1, 1'b1, 1'b1, 20'h12345, "R3 idle after reset");

        // R4 linear from start 1, R6 wrap
        cyc(1'b0, 1'b1, 1'b1, 20'h12341, "R2 proc load");
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 20'h0, "R4 R6 linear advance");
        cyc(1'b1, 1'b1, 1'b1, 20'hFFFFF, "R3 hold, start_addr ignored");
        cyc(1'b1, 1'b1, 1'b1, 20'h0, "R3 hold");
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 20'h0, "R4 R7 linear advance");

        // R5 interleaved from start 1 via controller strobe
        order_sel = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, 20'hF00A1, "R2 ctrl load");
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 20'h0, "R5 R6 interleaved advance");
        for (int s = 0; s < 4; s++) begin
            cyc(1'b1, 1'b0, 1'b1, AW'(20'h5A5A0 + s), "R2 ctrl load start");
            for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, (i == 2), 20'h0, "R5 R7 interleaved");
        end

        // R8 load priority with advance asserted
        cyc(1'b1, 1'b1, 1'b0, 20'h0, "R5 advance");
        cyc(1'b0, 1'b1, 1'b0, 20'h33332, "R8 proc load wins over advance");
        cyc(1'b1, 1'b0, 1'b0, 20'h44443, "R8 ctrl load wins over advance");
        cyc(1'b1, 1'b1, 1'b0, 20'h0, "R5 advance after load");

        // R9 both strobes together
        order_sel = 1'b0;
        cyc(1'b1, 1'b1, 1'b1, 20'h0, "R4 order change idle");
        cyc(1'b0, 1'b0, 1'b0, 20'h87652, "R9 both strobes");
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 20'h0, "R4 linear from 2");
        for (int s = 0; s < 4; s++) begin
            cyc(1'b0, 1'b1, 1'b1, AW'(20'hFFFFC + s), "R2 load top region");
            for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 20'h0, "R4 R7 linear top");
        end

        // reset mid-burst
        rst = 1'b1;
        cyc(1'b1, 1'b1, 1'b0, 20'h0, "R1 reset mid-burst");
        rst = 1'b0;
        cyc(1'b1, 1'b1, 1'b0, 20'h0, "R6 advance from zero");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule